// File: doc/BRIEF.md
# Sixteen-Bit Carry-Skip Adder

This block adds two 16-bit unsigned operands and a single carry-in bit. It is purely combinational. The operand width is cut into four slices of four bits. Each slice ripples its carry from bit to bit. Each slice also has a bypass term that moves an incoming carry straight to the next slice when every bit of the slice propagates.

The carry out of a slice is never picked by a two-way selector. It is the OR of two terms:
- the slice's own rippled carry-out;
- the incoming carry ANDed with all of the slice's propagate bits.

A carry that the slice generates internally therefore always reaches the next slice. The slowest path starts at the low slice's operands, runs through the bypass terms and ends at sum bit 15. The final carry-out bypass is not on it.

The three carries between slices are brought out as ports, so the block can be checked slice by slice. The block is meant to sit inside a datapath that registers its inputs and outputs elsewhere.

Top module: `carry_skip_add16`

## Requirements
- R1: `{carry_out, sum}` equals `op_a + op_b + carry_in` taken as a 17-bit unsigned sum, for every input combination.
- R2: `grp_carry[k]` (k = 0..2, least significant first) equals the true carry into bit 4(k+1), that is bit 4(k+1) of the sum of the low 4(k+1) bits of both operands plus `carry_in`.
- R3: A carry generated inside a slice reaches the next slice's carry input, and it also reaches the upper slices whose bits all propagate.
- R4: When any bit of a slice has `op_a` equal to `op_b` (propagate 0), the carry out of that slice depends only on that slice's operand bits and not on its carry-in.
- R5: When every bit of a slice has `op_a` different from `op_b` (all propagate), the carry out of that slice equals the carry into that slice.
- R6: All-ones plus zero with `carry_in` = 1 gives `sum` = 0 and `carry_out` = 1. All-zero inputs give `sum` = 0 and `carry_out` = 0.
- R7: Sum bit 0 is `op_a[0] XOR op_b[0] XOR carry_in`, so the external carry-in enters the lowest slice directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the result |
| carry_out | output | 1 | Carry out of bit 15 |
| grp_carry | output | 3 | Carries into bits 4, 8 and 12 |

## Verification
The assertions are immediate checks, evaluated whenever the inputs settle. They assume the operands and carry-in are two-state values with no X or Z, because any unknown bit would poison the reference sums they compare against.

The stimulus drives only fully defined values. It changes them just after a clock edge and compares at the following falling edge, so the combinational network has settled before any comparison. The directed operands are chosen so that each slice is made fully propagating, partly propagating and internally generating, in turn.

// File: rtl/cskip_pkg.sv
package cskip_pkg;
   localparam int SLICE_BITS  = 4;
   localparam int SLICE_COUNT = 4;
   localparam int ADD_WIDTH   = SLICE_BITS * SLICE_COUNT;
endpackage

// File: rtl/pg_bits.sv
module pg_bits #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] prop,
   output logic [W-1:0] gen
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign prop[i] = a[i] ^ b[i];
      assign gen[i]  = a[i] & b[i];
   end
endmodule

// File: rtl/ripple_slice.sv
module ripple_slice #(
   parameter int N = 4
) (
   input  logic [N-1:0] prop,
   input  logic [N-1:0] gen,
   input  logic         cin,
   output logic [N-1:0] cbit,
   output logic         cout
);
   logic [N:0] chain;
   assign chain[0] = cin;
   for (genvar i = 0; i < N; i++) begin : g_rip
      assign chain[i+1] = gen[i] | (prop[i] & chain[i]);
   end
   assign cbit = chain[N-1:0];
   assign cout = chain[N];
endmodule

// File: rtl/skip_merge.sv
module skip_merge #(
   parameter int N = 4
) (
   input  logic [N-1:0] prop,
   input  logic         cin,
   input  logic         rip_cout,
   output logic         cout
);
   logic all_prop;
   assign all_prop = &prop;
   assign cout = (cin & all_prop) | rip_cout;
endmodule

// File: rtl/carry_skip_add16.sv
module carry_skip_add16
   import cskip_pkg::*;
#(
   parameter int SB = SLICE_BITS,
   parameter int SC = SLICE_COUNT
) (
   input  logic [15:0] op_a,
   input  logic [15:0] op_b,
   input  logic        carry_in,
   output logic [15:0] sum,
   output logic        carry_out,
   output logic [2:0]  grp_carry
);
   localparam int W = SB * SC;

   if (W != 16 || SC != 4) begin : g_bad_cfg
      $error("carry_skip_add16: slice configuration must total 16 bits in four slices");
   end

   logic [W-1:0] prop, gen, cbit;
   logic [SC:0]  slice_c;

   pg_bits #(.W(W)) u_pg (.a(op_a), .b(op_b), .prop(prop), .gen(gen));

   assign slice_c[0] = carry_in;

   for (genvar s = 0; s < SC; s++) begin : g_slice
      logic rip_out;
      ripple_slice #(.N(SB)) u_rip (
         .prop(prop[s*SB +: SB]),
         .gen (gen[s*SB +: SB]),
         .cin (slice_c[s]),
         .cbit(cbit[s*SB +: SB]),
         .cout(rip_out)
      );
      skip_merge #(.N(SB)) u_skip (
         .prop    (prop[s*SB +: SB]),
         .cin     (slice_c[s]),
         .rip_cout(rip_out),
         .cout    (slice_c[s+1])
      );
   end

   assign sum       = prop ^ cbit;
   assign carry_out = slice_c[SC];
   assign grp_carry = slice_c[SC-1:1];
endmodule

// File: rtl/carry_skip_add16_chk.sv
module carry_skip_add16_chk (
   input logic [15:0] op_a,
   input logic [15:0] op_b,
   input logic        carry_in,
   input logic [15:0] sum,
   input logic        carry_out,
   input logic [2:0]  grp_carry
);
   logic [3:0]  s_in, s_out;
   logic [16:0] total;

   assign s_in  = {grp_carry, carry_in};
   assign s_out = {carry_out, grp_carry};
   assign total = 17'(op_a) + 17'(op_b) + 17'(carry_in);

   always_comb begin
      // R1
      full_sum_chk: assert ({carry_out, sum} == total);
      // R7
      low_bit_chk: assert (sum[0] == (op_a[0] ^ op_b[0] ^ carry_in));
      for (int k = 0; k < 3; k++) begin
         logic [16:0] msk, part;
         msk  = (17'd1 << (4*(k+1))) - 17'd1;
         part = (17'(op_a) & msk) + (17'(op_b) & msk) + 17'(carry_in);
         // R2
         slice_carry_chk: assert (grp_carry[k] == part[4*(k+1)]);
      end
      for (int k = 0; k < 4; k++) begin
         logic [4:0] own;
         own = 5'(op_a[k*4 +: 4]) + 5'(op_b[k*4 +: 4]);
         // R4
         if (!(&(op_a[k*4 +: 4] ^ op_b[k*4 +: 4])))
            blocked_slice_chk: assert (s_out[k] == own[4]);
         // R5
         else
            bypass_slice_chk: assert (s_out[k] == s_in[k]);
      end
   end
endmodule

bind carry_skip_add16 carry_skip_add16_chk u_chk (
   .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
   .sum(sum), .carry_out(carry_out), .grp_carry(grp_carry)
);

// File: tb/carry_skip_add16_test.sv
module carry_skip_add16_test;
   logic        clk = 1'b0;
   logic [15:0] a = '0, b = '0;
   logic        ci = 1'b0;
   logic [15:0] s;
   logic        co;
   logic [2:0]  gc;
   int checks = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   carry_skip_add16 uut (.op_a(a), .op_b(b), .carry_in(ci),
                         .sum(s), .carry_out(co), .grp_carry(gc));

   function automatic int ref_total(int x, int y, int c);
      return x + y + c;
   endfunction

   function automatic int ref_cin(int x, int y, int c, int k);
      int m;
      m = (1 << (4*(k+1))) - 1;
      return (((x & m) + (y & m) + c) >> (4*(k+1))) & 1;
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic apply(int x, int y, int c);
      @(posedge clk);
      #1;
      a = x[15:0]; b = y[15:0]; ci = c[0];
      @(negedge clk);
      check("R1 sum", int'({co, s}), ref_total(x, y, c));
      for (int k = 0; k < 3; k++)
         check("R2 slice carry", int'(gc[k]), ref_cin(x, y, c, k));
      check("R7 bit0", int'(s[0]), (x ^ y ^ c) & 1);
   endtask

   initial begin
      #1;
      check("R6 zero inputs", int'({co, s}), 0);
      apply(0, 0, 0);
      check("R6 zeros", int'({co, s}), 0);
      apply(16'hFFFF, 0, 1);
      check("R6 ones plus one", int'({co, s}), 17'h10000);
      apply(16'hAAAA, 16'h5555, 1);
      check("R5 all propagate cin1", int'({co, gc}), 4'hF);
      apply(16'hAAAA, 16'h5555, 0);
      check("R5 all propagate cin0", int'({co, gc}), 0);
      apply(16'h00F8, 16'h0008, 0);
      check("R3 generated carry skips slice1", int'(gc), 3'b011);
      apply(16'h000F, 16'h0001, 0);
      check("R3 generated carry low", int'(gc[0]), 1);
      apply(16'h0F38, 16'h00C3, 0);
      check("R4 blocked cin0", int'(gc[0]), 0);
      apply(16'h0F38, 16'h00C3, 1);
      check("R4 blocked cin1", int'(gc[0]), 0);
      apply(16'h0039, 16'h0009, 0);
      check("R4 blocked gen cin0", int'(gc[0]), 1);
      apply(16'h0039, 16'h0009, 1);
      check("R4 blocked gen cin1", int'(gc[0]), 1);
      for (int i = 0; i < 300; i++)
         apply(int'($urandom() & 16'hFFFF), int'($urandom() & 16'hFFFF), int'($urandom() & 1));
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule